// File: doc/BRIEF.md
# Dual-Mode Serial Result Transmitter

This block sends a converter's 12-bit result out one bit at a time, most significant bit first. It runs in one of two clocking modes. In self-clocked mode, each convert command loads the result held from the previous conversion and makes a burst of exactly twelve data clock pulses on `dclk_out`. In host-clocked mode, the block follows a data clock that the host drives on `ext_dclk`. A read command arms a frame. The block marks the frame with a `sync_out` pulse and then shifts the result out. Bits taken from `tag_in` follow the result, delayed by twelve clocks, so that several converters can be chained on one data line.

The result arrives from the converter core on a valid/ready input. `res_ready` is always high, so the block never applies back-pressure. A result is taken into the holding register in any cycle where `res_valid` is high, and it stays there until the next one arrives. The shifter loads from the holding register only when a command arrives. A transfer in progress is therefore never disturbed by a new result. The host controls the block with plain level pins: chip select `cs_n`, read/convert `rc`, the mode pin and the coding pin. All of these are synchronous to `clk`. The host data clock is asynchronous and passes through a synchroniser inside the block.

Top module: `serial_result_tx`

## Requirements
- R1: In self-clocked mode (`ext_mode`=0), a convert command produces exactly 12 rising edges on `dclk_out`, and `dclk_out` then stays low until the next convert command. A convert command is a high-to-low transition of `cs_n OR rc`. Each half period of `dclk_out` lasts `DCLK_HALF` clock cycles.
- R2: The result is sent with bit 11 first and bit 0 last. In self-clocked mode, `data_out` changes only while `dclk_out` is low, so each bit is stable across the rising edge that follows it.
- R3: In self-clocked mode, after a burst ends `data_out` holds the level that `tag_in` had at the convert command. Later changes on `tag_in` have no effect on it.
- R4: In host-clocked mode, a read command arms a frame. A read command is either a rise of `rc` while `cs_n` is low, or a fall of `cs_n` while `rc` is high. At the first rising edge of `ext_dclk` after the read command, `sync_out` goes high. It goes low again at the next rising edge.
- R5: In host-clocked mode, `data_out` shows bit 11 from the read command onward. After each `ext_dclk` rising edge from the second edge of the frame onward, `data_out` advances by one bit. A host that samples at rising edges 1 to 12 after the sync edge therefore reads bit 11 down to bit 0.
- R6: In host-clocked mode, shifting takes place only while `cs_n` is low and `rc` is high. In that state, the level of `tag_in` at sync-relative edge k appears on `data_out` at edge k+12. While `cs_n` is high, `ext_dclk` edges leave `data_out` unchanged.
- R7: The result from the core is straight binary. When `straight_fmt`=1 it is sent unchanged (for example 800 for midscale and FFF for full scale). When `straight_fmt`=0 it is sent in two's complement, which means bit 11 is inverted (800 becomes 000, and 000 becomes 800).
- R8: In host-clocked mode, a read returns the most recent result accepted before the read command. A read issued while conversion n is still running therefore returns result n-1, and a read issued after result n arrives returns n.
- R9: In self-clocked mode, a convert command sends the result held when the command arrives, which is the result of the previous conversion.
- R10: `res_ready` is always 1, and a result is accepted in every cycle in which `res_valid` is 1.
- R11: After reset, `data_out`, `sync_out` and `dclk_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| res_data | input | 12 | Straight-binary conversion result |
| res_valid | input | 1 | Result valid strobe |
| res_ready | output | 1 | Result accepted (always 1) |
| ext_mode | input | 1 | 1: host-clocked mode, 0: self-clocked mode |
| straight_fmt | input | 1 | 1: straight binary, 0: two's complement |
| cs_n | input | 1 | Chip select, active low |
| rc | input | 1 | Read/convert control |
| tag_in | input | 1 | Daisy-chain serial input |
| ext_dclk | input | 1 | Host data clock (asynchronous) |
| data_out | output | 1 | Serial data |
| sync_out | output | 1 | Frame marker in host-clocked mode |
| dclk_out | output | 1 | Generated data clock in self-clocked mode |

## Verification
The hardest case to reach from the ports is a host-clocked frame that reads the older result while a conversion is running. A second hard case is the hand-over at edge 13, where the tag bits replace the result bits. The stimulus starts a conversion by lowering `rc` and then issues the read by raising `cs_n`, then `rc`, and then lowering `cs_n` again, all before the new result is presented. The host clock then runs for 24 edges while a distinct 12-bit tag pattern is driven, so every result bit and every delayed tag bit is checked in its place. A separate frame raises `cs_n` after the sync edge to show that the shifter stays still while shifting is disabled.

// File: rtl/srt_pkg.sv
`timescale 1ns/1ps
package srt_pkg;
  typedef enum logic [1:0] {
    FR_IDLE  = 2'd0,
    FR_ARMED = 2'd1,
    FR_RUN   = 2'd2
  } frame_st_t;
endpackage

// File: rtl/srt_edge_sync.sv
`timescale 1ns/1ps
module srt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~last;
endmodule

// File: rtl/srt_dclk_burst.sv
`timescale 1ns/1ps
module srt_dclk_burst #(
  parameter int HALF   = 4,
  parameter int PULSES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic dclk,
  output logic active,
  output logic shift
);
  localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam int PW = $clog2(PULSES + 1);

  logic [CW-1:0] half_cnt;
  logic [PW-1:0] pulse_cnt;
  logic          pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      dclk      <= 1'b0;
      half_cnt  <= '0;
      pulse_cnt <= '0;
      pend      <= 1'b0;
    end else if (start) begin
      active    <= 1'b1;
      dclk      <= 1'b0;
      half_cnt  <= '0;
      pulse_cnt <= '0;
      pend      <= 1'b0;
    end else begin
      pend <= 1'b0;
      if (active) begin
        if (half_cnt == CW'(HALF - 1)) begin
          half_cnt <= '0;
          if (!dclk) begin
            dclk <= 1'b1;
          end else begin
            dclk      <= 1'b0;
            pend      <= 1'b1;
            pulse_cnt <= pulse_cnt + 1'b1;
            if (pulse_cnt == PW'(PULSES - 1)) active <= 1'b0;
          end
        end else begin
          half_cnt <= half_cnt + 1'b1;
        end
      end
    end
  end

  // shift one cycle after the falling edge, while the clock is low
  assign shift = pend;
endmodule

// File: rtl/srt_shifter.sv
`timescale 1ns/1ps
module srt_shifter #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         ser_in,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr <= '0;
    else if (load)  sr <= load_val;
    else if (shift) sr <= {sr[W-2:0], ser_in};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/srt_ext_frame.sv
`timescale 1ns/1ps
module srt_ext_frame
  import srt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic read_evt,
  input  logic dclk_rise,
  input  logic gate,
  output logic sync,
  output logic shift
);
  frame_st_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= FR_IDLE;
      sync <= 1'b0;
    end else if (read_evt) begin
      st   <= FR_ARMED;
      sync <= 1'b0;
    end else begin
      case (st)
        FR_ARMED: if (dclk_rise) begin
          sync <= 1'b1;
          st   <= FR_RUN;
        end
        FR_RUN:   if (dclk_rise) sync <= 1'b0;
        default:  st <= st;
      endcase
    end
  end

  assign shift = (st == FR_RUN) & dclk_rise & gate;
endmodule

// File: rtl/serial_result_tx.sv
`timescale 1ns/1ps
module serial_result_tx #(
  parameter int DATA_W      = 12,
  parameter int DCLK_HALF   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] res_data,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic              ext_mode,
  input  logic              straight_fmt,
  input  logic              cs_n,
  input  logic              rc,
  input  logic              tag_in,
  input  logic              ext_dclk,
  output logic              data_out,
  output logic              sync_out,
  output logic              dclk_out
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] held;
  logic [DATA_W-1:0] coded;
  logic              tag_hold;
  logic              prev_sel, prev_rd;
  logic              sel_lvl, rd_lvl;
  logic              conv_evt, rd_evt, int_start;
  logic              ext_rise, ext_shift, int_shift, int_active;
  logic              load, shift, ser_in;

  assign res_ready = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         held <= '0;
    else if (res_valid) held <= res_data;
  end

  // chip select is combined with read/convert for the convert command
  assign sel_lvl   = cs_n | rc;
  assign rd_lvl    = ~cs_n & rc;
  assign conv_evt  = prev_sel & ~sel_lvl;
  assign rd_evt    = ext_mode & ~prev_rd & rd_lvl;
  assign int_start = conv_evt & ~ext_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_sel <= 1'b1;
      prev_rd  <= 1'b1;
      tag_hold <= 1'b0;
    end else begin
      prev_sel <= sel_lvl;
      prev_rd  <= rd_lvl;
      if (int_start) tag_hold <= tag_in;
    end
  end

  always_comb begin
    coded = held;
    if (!straight_fmt) coded[MSB] = ~held[MSB];
  end

  srt_edge_sync #(.STAGES(SYNC_STAGES)) u_xsync (
    .clk(clk), .rst_n(rst_n), .din(ext_dclk), .rise(ext_rise)
  );

  srt_dclk_burst #(.HALF(DCLK_HALF), .PULSES(DATA_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(int_start),
    .dclk(dclk_out), .active(int_active), .shift(int_shift)
  );

  srt_ext_frame u_frame (
    .clk(clk), .rst_n(rst_n), .read_evt(rd_evt), .dclk_rise(ext_rise),
    .gate(rd_lvl), .sync(sync_out), .shift(ext_shift)
  );

  assign load   = int_start | rd_evt;
  assign shift  = ext_mode ? ext_shift : int_shift;
  assign ser_in = ext_mode ? tag_in : tag_hold;

  srt_shifter #(.W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(coded),
    .shift(shift), .ser_in(ser_in), .msb(data_out)
  );
endmodule

// File: rtl/srt_checker.sv
`timescale 1ns/1ps
module srt_checker #(
  parameter int PULSES = 12
) (
  input logic clk,
  input logic rst_n,
  input logic ext_mode,
  input logic data_out,
  input logic dclk_out,
  input logic sync_out,
  input logic int_start,
  input logic int_active
);
  localparam int CW = $clog2(PULSES + 2);
  logic [CW-1:0] rises;
  logic          dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rises  <= '0;
      dclk_q <= 1'b0;
    end else begin
      dclk_q <= dclk_out;
      if (int_start) rises <= '0;
      else if (dclk_out && !dclk_q && rises != CW'(PULSES + 1)) rises <= rises + 1'b1;
    end
  end

  p_burst_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rises <= CW'(PULSES));

  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_active && !int_start) |=> !dclk_out);

  p_data_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$past(ext_mode) && !$stable(data_out)) |-> !dclk_out);

  p_sync_ext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> ext_mode);
endmodule

bind serial_result_tx srt_checker #(.PULSES(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .data_out(data_out),
  .dclk_out(dclk_out), .sync_out(sync_out), .int_start(int_start),
  .int_active(int_active)
);

// File: tb/tb_serial_result_tx.sv
`timescale 1ns/1ps
module tb_serial_result_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] res_data = '0;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic        ext_mode = 1'b0;
  logic        straight_fmt = 1'b1;
  logic        cs_n = 1'b1;
  logic        rc = 1'b1;
  logic        tag_in = 1'b0;
  logic        ext_dclk = 1'b0;
  logic        data_out, sync_out, dclk_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_result_tx #(.DATA_W(12), .DCLK_HALF(4), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .res_data(res_data), .res_valid(res_valid),
    .res_ready(res_ready), .ext_mode(ext_mode), .straight_fmt(straight_fmt),
    .cs_n(cs_n), .rc(rc), .tag_in(tag_in), .ext_dclk(ext_dclk),
    .data_out(data_out), .sync_out(sync_out), .dclk_out(dclk_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic give_result(input logic [11:0] v);
    res_data  = v;
    res_valid = 1'b1;
    tick(1);
    res_valid = 1'b0;
    tick(1);
  endtask

  task automatic ext_pulse();
    ext_dclk = 1'b1;
    tick(8);
    ext_dclk = 1'b0;
    tick(8);
  endtask

  // self-clocked burst: R1, R2, R3, R7, R9
  task automatic t_int_burst(input logic [11:0] exp, input bit fmt, input bit tg);
    logic [11:0] bits = '0;
    int          n = 0;
    logic        prev = 1'b0;
    ext_mode = 1'b0;
    straight_fmt = fmt;
    tag_in = tg;
    cs_n = 1'b0;
    rc = 1'b1;
    tick(2);
    rc = 1'b0;
    tick(1);
    tag_in = ~tg;
    for (int i = 0; i < 200; i++) begin
      if (dclk_out && !prev) begin
        bits = {bits[10:0], data_out};
        n++;
      end
      prev = dclk_out;
      tick(1);
    end
    check(n == 12, "R1 pulse count", n, 12);
    check(dclk_out == 1'b0, "R1 clock low after burst", dclk_out, 0);
    check(bits == exp, "R2/R7/R9 burst word", bits, exp);
    check(data_out == tg, "R3 captured tag held", data_out, tg);
    rc = 1'b1;
    tick(2);
  endtask

  // host-clocked frame: R4, R5, R6, R8
  task automatic t_ext_read(input logic [11:0] exp, input logic [11:0] tg, input bit use_cs);
    logic [23:0] got = '0;
    ext_mode = 1'b1;
    if (use_cs) begin
      cs_n = 1'b1;
      tick(1);
      rc = 1'b1;
      tick(2);
      cs_n = 1'b0;
    end else begin
      cs_n = 1'b0;
      rc = 1'b0;
      tick(2);
      rc = 1'b1;
    end
    tick(3);
    check(sync_out == 1'b0, "R4 sync low before first edge", sync_out, 0);
    ext_pulse();
    check(sync_out == 1'b1, "R4 sync high after read edge", sync_out, 1);
    for (int k = 0; k < 24; k++) begin
      if (k == 1) check(sync_out == 1'b0, "R4 sync one period", sync_out, 0);
      got = {got[22:0], data_out};
      tag_in = (k < 12) ? tg[11-k] : 1'b0;
      ext_pulse();
    end
    check(got[23:12] == exp, "R5/R8 result bits", got[23:12], exp);
    check(got[11:0] == tg, "R6 tag delayed by 12", got[11:0], tg);
  endtask

  // host-clocked: no shift while chip select is high (R6)
  task automatic t_ext_gate(input logic [11:0] exp);
    ext_mode = 1'b1;
    rc = 1'b1;
    cs_n = 1'b1;
    tick(2);
    cs_n = 1'b0;
    tick(3);
    ext_pulse();
    check(sync_out == 1'b1, "R4 sync on chip-select read", sync_out, 1);
    check(data_out == exp[11], "R5 first bit", data_out, exp[11]);
    cs_n = 1'b1;
    tag_in = ~exp[11];
    repeat (3) ext_pulse();
    check(data_out == exp[11], "R6 no shift with cs_n high", data_out, exp[11]);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    check(data_out == 1'b0, "R11 data reset", data_out, 0);
    check(sync_out == 1'b0, "R11 sync reset", sync_out, 0);
    check(dclk_out == 1'b0, "R11 dclk reset", dclk_out, 0);
    check(res_ready == 1'b1, "R10 ready high", res_ready, 1);

    give_result(12'hA5C);
    t_int_burst(12'hA5C, 1'b1, 1'b1);
    give_result(12'h3F0);
    t_int_burst(12'hBF0, 1'b0, 1'b0);
    give_result(12'h800);
    t_int_burst(12'h000, 1'b0, 1'b1);
    give_result(12'hFFF);
    t_int_burst(12'hFFF, 1'b1, 1'b0);

    straight_fmt = 1'b1;
    give_result(12'h123);
    t_ext_read(12'h123, 12'hC35, 1'b0);
    cs_n = 1'b0;
    rc = 1'b0;
    tick(4);
    t_ext_read(12'h123, 12'h5A9, 1'b1);
    cs_n = 1'b0;
    rc = 1'b0;
    tick(2);
    give_result(12'h9AB);
    straight_fmt = 1'b0;
    t_ext_read(12'h1AB, 12'h0F1, 1'b0);
    t_ext_gate(12'h1AB);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule